// File: doc/BRIEF.md
# High/Low-Time Programmable Clock Divider

This block divides its input clock by an integer ratio taken from a 32-bit control word. The word carries two independent phase counts: a high-time count and a low-time count. Their sum is the divide ratio. The word also holds an odd-ratio marker bit, a bypass bit and a staging bit. The block produces two outputs. `clk_en` is a one-cycle enable that marks the first cycle of every output period. `div_clk` is a level that is high for the high-time cycles and low for the low-time cycles. The running ratio appears on `ratio`.

Software loads the word through a single-cycle write strobe. A write with the staging bit set only updates a shadow copy. A write with the staging bit clear also arms a transfer. The shadow-to-active transfer happens at the end of the output period that is running at that moment, so the output never shows a shortened period. The active word can be read back at any time. Its reserved upper bits read as zero.

Top module: `hl_clk_div`

## Requirements
- R1: Field layout: bits 5:0 are the low count, bits 11:6 the high count, bit 12 the odd-ratio marker, bit 13 bypass and bit 14 staging. `rd_data` returns bits 13:0 of the active word and reads zero in bits 31:14, whatever was written there.
- R2: When the active word has bit 13 set, `ratio` is 1, and `clk_en` and `div_clk` are both 1 in every cycle, whatever the count fields hold.
- R3: With bypass clear and both counts nonzero, `ratio` equals high count plus low count, and `clk_en` is high for exactly one cycle in every `ratio` cycles.
- R4: Within each period, `div_clk` is 1 for the first high-count cycles, starting with the cycle in which `clk_en` is 1. It is 0 for the remaining low-count cycles.
- R5: An unbypassed active word with a zero high count or a zero low count behaves as ratio 1, exactly as described in R2.
- R6: A write with bit 14 set leaves `rd_data`, `ratio`, `clk_en` and `div_clk` unchanged for as long as no later write with bit 14 clear occurs.
- R7: A write with bit 14 clear takes effect at the end of the current output period. The old word stays visible through the last cycle of that period. The new word is visible from the next cycle, and in that cycle `clk_en` is 1.
- R8: The word that gets transferred is the most recent write of either kind that arrived before the period boundary. A staged write that follows a commit inside the same period replaces the word that is applied.
- R9: After reset the active word is 0x0000_2000 (bypass), `ratio` is 1, and no transfer is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Active control word; reserved bits read as zero |
| ratio | output | 7 | Effective divide ratio of the active word |
| clk_en | output | 1 | High in the first cycle of every output period |
| div_clk | output | 1 | Divided clock level: high phase, then low phase |

## Verification
A corrupted phase counter shows up as a `clk_en` pulse at the wrong distance from the previous one, or as a `div_clk` edge at the wrong place. Either error is visible within one output period, at most 126 cycles. A wrong active or shadow register shows up on `rd_data` and `ratio` in the cycle after the next period boundary. A transfer taken at the wrong moment shows up as a change of `rd_data` in a cycle where `clk_en` is low. The bench compares every output on every cycle against a model built from the requirements, so a divergence is reported in the cycle it first appears.

// File: rtl/hl_div_pkg.sv
package hl_div_pkg;
   // default width of one phase-count field
   localparam int unsigned DEF_CNT_W  = 6;
   localparam int unsigned DEF_WORD_W = 32;

   // bit positions derived from the count-field width
   function automatic int unsigned pos_edge(int unsigned cnt_w);
      return 2 * cnt_w;
   endfunction

   function automatic int unsigned pos_bypass(int unsigned cnt_w);
      return 2 * cnt_w + 1;
   endfunction

   function automatic int unsigned pos_hold(int unsigned cnt_w);
      return 2 * cnt_w + 2;
   endfunction
endpackage

// File: rtl/hl_div_decode.sv
module hl_div_decode
   import hl_div_pkg::*;
#(
   parameter int unsigned CNT_W = DEF_CNT_W,
   localparam int unsigned RAT_W = CNT_W + 1
) (
   input  logic [CNT_W-1:0] hi_cnt,
   input  logic [CNT_W-1:0] lo_cnt,
   input  logic             bypass,
   output logic [RAT_W-1:0] ratio,
   output logic             pass
);
   logic zero_field;

   assign zero_field = (hi_cnt == '0) || (lo_cnt == '0);
   assign pass       = bypass || zero_field;
   assign ratio      = pass ? RAT_W'(1)
                            : (RAT_W'(hi_cnt) + RAT_W'(lo_cnt));
endmodule

// File: rtl/hl_div_ctrl.sv
module hl_div_ctrl #(
   parameter int unsigned     SPAN       = 14,
   parameter logic [SPAN-1:0] RESET_SPAN = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [SPAN-1:0] wr_word,
   input  logic            wr_hold,
   input  logic            period_end,
   output logic [SPAN-1:0] active
);
   logic [SPAN-1:0] shadow_q;
   logic [SPAN-1:0] active_q;
   logic            armed_q;

   // shadow: last written word of either kind
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= RESET_SPAN;
      end else if (wr_en) begin
         shadow_q <= wr_word;
      end
   end

   // arm on commit writes; the transfer clears it unless a commit arrives at the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (wr_en && !wr_hold) begin
         armed_q <= 1'b1;
      end else if (period_end) begin
         armed_q <= 1'b0;
      end
   end

   // active word changes only at a period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= RESET_SPAN;
      end else if (period_end && armed_q) begin
         active_q <= shadow_q;
      end
   end

   assign active = active_q;
endmodule

// File: rtl/hl_div_phase.sv
module hl_div_phase
   import hl_div_pkg::*;
#(
   parameter int unsigned CNT_W = DEF_CNT_W,
   localparam int unsigned RAT_W = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RAT_W-1:0] ratio,
   input  logic [CNT_W-1:0] hi_cnt,
   input  logic             pass,
   output logic             clk_en,
   output logic             div_clk,
   output logic             period_end
);
   logic [RAT_W-1:0] cnt_q;

   assign period_end = (cnt_q >= (ratio - RAT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (period_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + RAT_W'(1);
      end
   end

   assign clk_en  = (cnt_q == '0);
   assign div_clk = pass || (cnt_q < RAT_W'(hi_cnt));
endmodule

// File: rtl/hl_clk_div.sv
module hl_clk_div
   import hl_div_pkg::*;
#(
   parameter int unsigned        CNT_W      = DEF_CNT_W,
   parameter int unsigned        WORD_W     = DEF_WORD_W,
   parameter logic [WORD_W-1:0]  RESET_WORD = WORD_W'(1) << (2 * CNT_W + 1),
   localparam int unsigned       RAT_W      = CNT_W + 1,
   localparam int unsigned       SPAN       = 2 * CNT_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data,
   output logic [RAT_W-1:0]  ratio,
   output logic              clk_en,
   output logic              div_clk
);
   localparam int unsigned HOLD_B = pos_hold(CNT_W);
   localparam int unsigned BYP_B  = pos_bypass(CNT_W);

   if (CNT_W < 2 || CNT_W > 12) begin : g_bad_cnt
      $error("hl_clk_div: CNT_W out of range");
   end
   if (WORD_W < SPAN + 1) begin : g_bad_word
      $error("hl_clk_div: WORD_W too small for the field layout");
   end

   logic [SPAN-1:0]  active;
   logic [CNT_W-1:0] hi_cnt;
   logic [CNT_W-1:0] lo_cnt;
   logic             pass;
   logic             period_end;

   if (WORD_W > SPAN + 1) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^wr_data[WORD_W-1:SPAN+1];
   end

   hl_div_ctrl #(
      .SPAN       (SPAN),
      .RESET_SPAN (RESET_WORD[SPAN-1:0])
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_word    (wr_data[SPAN-1:0]),
      .wr_hold    (wr_data[HOLD_B]),
      .period_end (period_end),
      .active     (active)
   );

   assign lo_cnt = active[CNT_W-1:0];
   assign hi_cnt = active[2*CNT_W-1:CNT_W];

   hl_div_decode #(.CNT_W(CNT_W)) dec_i (
      .hi_cnt (hi_cnt),
      .lo_cnt (lo_cnt),
      .bypass (active[BYP_B]),
      .ratio  (ratio),
      .pass   (pass)
   );

   hl_div_phase #(.CNT_W(CNT_W)) phase_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ratio      (ratio),
      .hi_cnt     (hi_cnt),
      .pass       (pass),
      .clk_en     (clk_en),
      .div_clk    (div_clk),
      .period_end (period_end)
   );

   assign rd_data = {{(WORD_W-SPAN){1'b0}}, active};
endmodule

// File: rtl/hl_clk_div_chk.sv
module hl_clk_div_chk
   import hl_div_pkg::*;
#(
   parameter int unsigned CNT_W  = DEF_CNT_W,
   parameter int unsigned WORD_W = DEF_WORD_W,
   localparam int unsigned RAT_W = CNT_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [WORD_W-1:0] wr_data,
   input logic [WORD_W-1:0] rd_data,
   input logic [RAT_W-1:0]  ratio,
   input logic              clk_en,
   input logic              div_clk
);
   localparam int unsigned HB = pos_hold(CNT_W);
   localparam int unsigned BB = pos_bypass(CNT_W);

   logic unused_chk;
   assign unused_chk = wr_en ^ (^wr_data);

   logic [CNT_W-1:0] a_lo, a_hi;
   assign a_lo = rd_data[CNT_W-1:0];
   assign a_hi = rd_data[2*CNT_W-1:CNT_W];

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[WORD_W-1:HB] == '0);                                    // R1
   AST_BYPASS_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[BB] |-> ratio == RAT_W'(1));                            // R2
   AST_PASS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      ratio == RAT_W'(1) |-> clk_en && div_clk);                       // R2
   AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[BB] && (a_lo == '0 || a_hi == '0)) |-> ratio == RAT_W'(1)); // R5
   AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> div_clk);                                              // R4
   AST_SWITCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data) |-> clk_en);                                    // R7
endmodule

bind hl_clk_div hl_clk_div_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) chk_i (.*);

// File: tb/hl_clk_div_tb_top.sv
module hl_clk_div_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic [6:0]  ratio;
   logic        clk_en;
   logic        div_clk;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [13:0] m_act, m_sh;
   bit          m_arm;
   int          m_cnt;

   always #5 clk = ~clk;

   hl_clk_div dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .ratio(ratio), .clk_en(clk_en), .div_clk(div_clk)
   );

   function automatic int eff(logic [13:0] w);
      if (w[13]) return 1;
      if (w[11:6] == 0 || w[5:0] == 0) return 1;
      return int'(w[11:6]) + int'(w[5:0]);
   endfunction

   function automatic logic [31:0] enc(int n, bit commit);
      logic [31:0] w = '0;
      w[5:0]  = 6'((n + 1) / 2);
      w[11:6] = 6'(n / 2);
      w[12]   = (n % 2) == 1;
      w[13]   = (n == 1);
      w[14]   = !commit;
      return w;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cmp_all();
      int r = eff(m_act);
      chk("R1", "rd_data", rd_data, {18'd0, m_act});
      chk("R3", "ratio", {25'd0, ratio}, 32'(r));
      chk("R3", "clk_en", {31'd0, clk_en}, {31'd0, m_cnt == 0});
      chk("R4", "div_clk", {31'd0, div_clk},
          {31'd0, (r == 1) || (m_cnt < int'(m_act[11:6]))});
   endtask

   task automatic model_edge(bit we, logic [31:0] d);
      if (m_cnt == eff(m_act) - 1) begin
         m_cnt = 0;
         if (m_arm) begin
            m_act = m_sh;
            m_arm = 0;
         end
      end else begin
         m_cnt++;
      end
      if (we) begin
         m_sh = d[13:0];
         if (!d[14]) m_arm = 1;
      end
   endtask

   task automatic step(bit we, logic [31:0] d);
      wr_en   = we;
      wr_data = d;
      @(posedge clk);
      model_edge(we, d);
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
      cmp_all();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, '0);
   endtask

   task automatic idle_to_cnt(int k);
      for (int i = 0; i < 300 && m_cnt != k; i++) step(1'b0, '0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(10 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      int hc;
      int seed_init;
      seed_init = int'($urandom(32'd20240611));
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
      m_act = 14'h2000; m_sh = 14'h2000; m_arm = 0; m_cnt = 0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", "reset rd_data", rd_data, 32'h0000_2000);
      chk("R9", "reset ratio", {25'd0, ratio}, 32'd1);
      rst_n = 1'b1;
      idle(4);

      // R7: commit from bypass, applied one boundary later
      step(1'b1, enc(5, 1));
      chk("R7", "before boundary", rd_data, 32'h0000_2000);
      step(1'b0, '0);
      chk("R7", "after boundary", rd_data, enc(5, 1));
      chk("R7", "clk_en at switch", {31'd0, clk_en}, 32'd1);
      idle(12);
      chk("R3", "ratio 5", {25'd0, ratio}, 32'd5);

      // R4: ratio 7 high for 3 cycles
      step(1'b1, enc(7, 1));
      idle(14);
      idle_to_cnt(0);
      hc = 0;
      for (int i = 0; i < 7; i++) begin
         if (div_clk) hc++;
         step(1'b0, '0);
      end
      chk("R4", "high cycles of 7", 32'(hc), 32'd3);

      // R8: commit then staged write inside one period
      step(1'b1, enc(40, 1));
      idle(60);
      idle_to_cnt(5);
      step(1'b1, enc(9, 1));
      step(1'b1, enc(12, 0));
      idle(90);
      chk("R8", "staged replaces commit", rd_data, enc(12, 0) & 32'h3FFF);
      chk("R8", "ratio 12", {25'd0, ratio}, 32'd12);

      // R6: staged write with reserved bits has no effect
      step(1'b1, enc(7, 0) | 32'hFFFF_0000);
      idle(60);
      chk("R6", "rd_data held", rd_data, enc(12, 0) & 32'h3FFF);
      chk("R6", "ratio held", {25'd0, ratio}, 32'd12);

      // R1: reserved bits ignored on commit
      step(1'b1, enc(3, 1) | 32'hABCD_8000);
      idle(30);
      chk("R1", "reserved masked", rd_data, enc(3, 1));

      // R5: zero high count, then zero low count
      step(1'b1, 32'h0000_0005);
      idle(10);
      chk("R5", "hi zero ratio", {25'd0, ratio}, 32'd1);
      step(1'b1, 32'h0000_0140);
      idle(4);
      chk("R5", "lo zero ratio", {25'd0, ratio}, 32'd1);
      chk("R5", "lo zero clk_en", {31'd0, clk_en}, 32'd1);

      // R2: bypass with nonzero counts
      step(1'b1, 32'h0000_2FFF);
      idle(4);
      chk("R2", "bypass ratio", {25'd0, ratio}, 32'd1);
      chk("R2", "bypass div_clk", {31'd0, div_clk}, 32'd1);

      // R3: largest ratio
      step(1'b1, 32'h0000_0FFF);
      idle(4);
      chk("R3", "max ratio", {25'd0, ratio}, 32'd126);
      idle(260);

      // random mix, checked every cycle against the model
      for (int it = 0; it < 300; it++) begin
         int n;
         logic [31:0] w;
         n = 1 + int'($urandom % 126);
         w = enc(n, ($urandom % 4) != 0);
         if ($urandom % 5 == 0) w = $urandom;
         step(1'b1, w);
         idle(int'($urandom % 160));
      end
      finish_run();
   end
endmodule